// File: doc/BRIEF.md
# Debug Register Access Router

This block sits between a host debug link and the rest of a processor subsystem. The host issues one command at a time: select a target, read a register, or write a register. The block forwards each read or write to whichever target is currently selected. The four targets are the CPU special-register space, a trace port, a local file of development-control registers, and the system memory bus. Each command ends with a single done pulse that carries an error code and, for reads, a data word.

The development registers are stored inside the block. The special-register space is reached through a word-wide request/acknowledge master port. The memory bus is reached through a byte-wide request/acknowledge master port. A memory word is moved as a burst of byte accesses to ascending addresses, with the most significant byte first. Memory addresses are checked against a configured window before any bus cycle starts. The trace target has no hardware behind it: reads return zero and writes are refused.

Top module: `dbg_chain_router`

## Requirements
- R1: After reset the selection is the global chain (code 0), `cmd_ready` is 1, `done`, `spr_req` and `mem_req` are 0, and any read or write made while the global chain is selected ends with error 1 and starts no bus cycle.
- R2: A select command (`cmd_op`=00) whose `cmd_addr` is 1 (special registers), 2 (trace), 3 (development registers) or 4 (memory bus) ends with error 0 and changes the selection. Any other value ends with error 1 and leaves the selection unchanged.
- R3: Every accepted command produces exactly one `done` pulse, one cycle wide. Its `done_err` is 0 for success, 1 for an invalid chain, 2 for an invalid address and 3 for an access exception. `cmd_op` 01 is a read and 1x is a write. Write commands return `done_rdata` 0.
- R4: With chain 1 selected, a read or write is forwarded on the special-register port, and the request is held until it is acknowledged. A read returns `spr_rdata` and error 0.
- R5: With chain 2 selected, a read returns data 0 and error 0, and a write returns error 3.
- R6: With chain 3 selected, addresses 0 to 16 are independent 32-bit read/write registers: 0 mode, 1 trace select, 2 qualifier select, 3 stop select, 4 CPU control, 5 to 15 the eleven watchpoint records, 16 the breakpoint record. All reset to 0.
- R7: With chain 3 selected, an address of 17 or above returns error 2. A read there returns 0, and a write there changes no register.
- R8: With chain 4 selected, a write of word W to address A issues exactly four byte writes to A, A+1, A+2 and A+3, carrying W[31:24], W[23:16], W[15:8] and W[7:0] in that order.
- R9: With chain 4 selected, a read at A issues four byte reads at A to A+3 and returns the byte from A in bits 31:24 and the byte from A+3 in bits 7:0.
- R10: A memory access is valid only when MEM_BASE <= A and A+4 <= MEM_BASE+MEM_SIZE (defaults 0x1000 and 0x1000). Any other address returns error 2 and issues no memory request.
- R11: While `spr_req` or `mem_req` waits for its acknowledge, the address, direction and write data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present; taken when cmd_ready is 1 |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 2 | 00 select, 01 read, 1x write |
| cmd_addr | input | 32 | Chain code for select; register or byte address otherwise |
| cmd_wdata | input | 32 | Write data |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 4 | Error code of the completed command |
| done_rdata | output | 32 | Read data of the completed command |
| spr_req | output | 1 | Special-register request |
| spr_we | output | 1 | Special-register write when 1 |
| spr_addr | output | 32 | Special-register address |
| spr_wdata | output | 32 | Special-register write data |
| spr_ack | input | 1 | Special-register acknowledge |
| spr_rdata | input | 32 | Special-register read data, valid with ack |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | Memory byte write when 1 |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory byte write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 8 | Memory byte read data, valid with ack |

## Verification
A corrupted selection register shows up on the next read or write as the wrong error code, or as activity on the wrong master port. The directed sequences probe this straight after every rejected select. A byte counter that slips shows as a byte lane landing at the wrong address, or as a fifth or a missing bus cycle, and this is visible within the same memory command. A development-register decode fault shows when a register is read back after all seventeen have been written with distinct values. A write to an out-of-range address that leaks into the file shows on the following readback.

// File: rtl/dbg_router_pkg.sv
package dbg_router_pkg;

   localparam int CHAIN_W = 3;
   localparam int ERR_W   = 4;

   typedef enum logic [CHAIN_W-1:0] {
      CH_GLOBAL = 3'd0,
      CH_SPR    = 3'd1,
      CH_TRACE  = 3'd2,
      CH_DEV    = 3'd3,
      CH_MEM    = 3'd4
   } chain_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SPR  = 2'd1,
      ST_MEM  = 2'd2
   } rstate_t;

   localparam logic [ERR_W-1:0] ERR_NONE    = 4'd0;
   localparam logic [ERR_W-1:0] ERR_CHAIN   = 4'd1;
   localparam logic [ERR_W-1:0] ERR_ADDR    = 4'd2;
   localparam logic [ERR_W-1:0] ERR_ACCESS  = 4'd3;

endpackage

// File: rtl/dbg_dev_regfile.sv
module dbg_dev_regfile #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int NUM_WP = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              addr_ok,
   output logic [DATA_W-1:0] rdata
);
   // five control registers, the watchpoint records, one breakpoint record
   localparam int NREG  = 5 + NUM_WP + 1;
   localparam int IDX_W = $clog2(NREG);

   if (NUM_WP < 1 || NUM_WP > 32) begin : g_bad_wp
      $error("dbg_dev_regfile: NUM_WP out of range");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_aw
      $error("dbg_dev_regfile: ADDR_W too small");
   end

   logic [DATA_W-1:0] regs [NREG];
   logic [IDX_W-1:0]  idx;

   assign addr_ok = (addr < ADDR_W'(NREG));
   assign idx     = addr[IDX_W-1:0];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs[g] <= '0;
         else if (wr_en && addr_ok && idx == IDX_W'(g))
            regs[g] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr_ok)
         rdata = regs[idx];
   end

endmodule

// File: rtl/dbg_mem_seq.sv
module dbg_mem_seq #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_we,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [DATA_W-1:0] start_wdata,
   output logic              fin,
   output logic [DATA_W-1:0] fin_word,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic              mem_ack,
   input  logic [7:0]        mem_rdata
);
   localparam int BYTES = DATA_W / 8;
   localparam int CNT_W = (BYTES > 1) ? $clog2(BYTES) : 1;

   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_dw
      $error("dbg_mem_seq: DATA_W must be a multiple of 8, at least 16");
   end

   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] base;
   logic [DATA_W-1:0] wbuf;
   logic [DATA_W-1:0] rbuf;
   logic              last;

   assign last      = (cnt == CNT_W'(BYTES - 1));
   assign mem_addr  = base + ADDR_W'(cnt);
   assign mem_wdata = wbuf[DATA_W-1 - 8*cnt -: 8];
   assign fin       = mem_req && mem_ack && last;
   assign fin_word  = {rbuf[DATA_W-9:0], mem_rdata};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_req <= 1'b0;
         mem_we  <= 1'b0;
         cnt     <= '0;
         base    <= '0;
         wbuf    <= '0;
         rbuf    <= '0;
      end else if (start) begin
         mem_req <= 1'b1;
         mem_we  <= start_we;
         cnt     <= '0;
         base    <= start_addr;
         wbuf    <= start_wdata;
         rbuf    <= '0;
      end else if (mem_req && mem_ack) begin
         rbuf <= {rbuf[DATA_W-9:0], mem_rdata};
         if (last)
            mem_req <= 1'b0;
         else
            cnt <= cnt + 1'b1;
      end
   end

   a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));

   a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && !last) |=> (mem_req && mem_addr == $past(mem_addr) + 1'b1));

endmodule

// File: rtl/dbg_chain_router.sv
module dbg_chain_router
   import dbg_router_pkg::*;
#(
   parameter int              ADDR_W   = 32,
   parameter int              DATA_W   = 32,
   parameter int              NUM_WP   = 11,
   parameter logic [ADDR_W-1:0] MEM_BASE = 32'h0000_1000,
   parameter logic [ADDR_W-1:0] MEM_SIZE = 32'h0000_1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              done,
   output logic [ERR_W-1:0]  done_err,
   output logic [DATA_W-1:0] done_rdata,
   output logic              spr_req,
   output logic              spr_we,
   output logic [ADDR_W-1:0] spr_addr,
   output logic [DATA_W-1:0] spr_wdata,
   input  logic              spr_ack,
   input  logic [DATA_W-1:0] spr_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic              mem_ack,
   input  logic [7:0]        mem_rdata
);
   localparam int BYTES = DATA_W / 8;

   if (ADDR_W < 8) begin : g_bad_aw
      $error("dbg_chain_router: ADDR_W too small");
   end
   if (MEM_SIZE < ADDR_W'(BYTES)) begin : g_bad_win
      $error("dbg_chain_router: memory window smaller than one word");
   end

   rstate_t state;
   chain_t  sel_q;
   logic    accept, is_sel, is_wr, id_ok, mem_ok;
   logic    dev_ok, dev_wr, mem_start, mem_fin;
   logic [DATA_W-1:0] dev_rdata, mem_word;
   logic [ADDR_W:0]   win_end, acc_end;

   assign cmd_ready = (state == ST_IDLE) && !done;
   assign accept    = cmd_valid && cmd_ready;
   assign is_sel    = (cmd_op == 2'b00);
   assign is_wr     = cmd_op[1];
   assign id_ok     = (cmd_addr >= ADDR_W'(CH_SPR)) && (cmd_addr <= ADDR_W'(CH_MEM));

   assign win_end = {1'b0, MEM_BASE} + {1'b0, MEM_SIZE};
   assign acc_end = {1'b0, cmd_addr} + (ADDR_W+1)'(BYTES);
   assign mem_ok  = (cmd_addr >= MEM_BASE) && (acc_end <= win_end);

   assign dev_wr    = accept && !is_sel && is_wr && (sel_q == CH_DEV);
   assign mem_start = accept && !is_sel && (sel_q == CH_MEM) && mem_ok;

   dbg_dev_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WP(NUM_WP)) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (dev_wr),
      .addr    (cmd_addr),
      .wdata   (cmd_wdata),
      .addr_ok (dev_ok),
      .rdata   (dev_rdata)
   );

   dbg_mem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mseq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (mem_start),
      .start_we    (is_wr),
      .start_addr  (cmd_addr),
      .start_wdata (cmd_wdata),
      .fin         (mem_fin),
      .fin_word    (mem_word),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .mem_ack     (mem_ack),
      .mem_rdata   (mem_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         sel_q      <= CH_GLOBAL;
         done       <= 1'b0;
         done_err   <= ERR_NONE;
         done_rdata <= '0;
         spr_req    <= 1'b0;
         spr_we     <= 1'b0;
         spr_addr   <= '0;
         spr_wdata  <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: if (accept) begin
               done_rdata <= '0;
               if (is_sel) begin
                  done     <= 1'b1;
                  done_err <= id_ok ? ERR_NONE : ERR_CHAIN;
                  if (id_ok)
                     sel_q <= chain_t'(cmd_addr[CHAIN_W-1:0]);
               end else begin
                  unique case (sel_q)
                     CH_SPR: begin
                        spr_req   <= 1'b1;
                        spr_we    <= is_wr;
                        spr_addr  <= cmd_addr;
                        spr_wdata <= cmd_wdata;
                        state     <= ST_SPR;
                     end
                     CH_TRACE: begin
                        done     <= 1'b1;
                        done_err <= is_wr ? ERR_ACCESS : ERR_NONE;
                     end
                     CH_DEV: begin
                        done     <= 1'b1;
                        done_err <= dev_ok ? ERR_NONE : ERR_ADDR;
                        if (!is_wr)
                           done_rdata <= dev_rdata;
                     end
                     CH_MEM: begin
                        if (mem_ok) begin
                           state <= ST_MEM;
                        end else begin
                           done     <= 1'b1;
                           done_err <= ERR_ADDR;
                        end
                     end
                     default: begin
                        done     <= 1'b1;
                        done_err <= ERR_CHAIN;
                     end
                  endcase
               end
            end
            ST_SPR: if (spr_ack) begin
               spr_req    <= 1'b0;
               done       <= 1'b1;
               done_err   <= ERR_NONE;
               done_rdata <= spr_we ? '0 : spr_rdata;
               state      <= ST_IDLE;
            end
            ST_MEM: if (mem_fin) begin
               done       <= 1'b1;
               done_err   <= ERR_NONE;
               done_rdata <= mem_we ? '0 : mem_word;
               state      <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r2_bad_select_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && is_sel && !id_ok) |=> $stable(sel_q));

   a_r11_spr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (spr_req && !spr_ack) |=> (spr_req && $stable(spr_addr) && $stable(spr_we)
                                 && $stable(spr_wdata)));

   a_r10_mem_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (sel_q == CH_MEM && !cmd_ready));

   a_r1_spr_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
      spr_req |-> (sel_q == CH_SPR && !cmd_ready));

   a_r7_dev_bad_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done && sel_q == CH_DEV && done_err == ERR_ADDR) |-> (done_rdata == '0));

   a_r5_trace_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done && sel_q == CH_TRACE) |-> (done_rdata == '0));

endmodule

// File: tb/test_dbg_chain_router.sv
module test_dbg_chain_router;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [1:0]  cmd_op = 2'b00;
   logic [31:0] cmd_addr = '0;
   logic [31:0] cmd_wdata = '0;
   logic        done;
   logic [3:0]  done_err;
   logic [31:0] done_rdata;
   logic        spr_req, spr_we;
   logic [31:0] spr_addr, spr_wdata;
   logic        spr_ack = 1'b0;
   logic [31:0] spr_rdata = '0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic        mem_ack = 1'b0;
   logic [7:0]  mem_rdata = '0;

   int errors = 0;
   int checks = 0;
   int spr_cycles = 0;
   int mem_cycles = 0;
   int hold_viol = 0;
   int pulse_viol = 0;
   logic [31:0] spr_store [16];
   logic [7:0]  bmem [256];
   logic [31:0] wr_addr_log [8];

   always #(CLK_PERIOD/2) clk = ~clk;

   dbg_chain_router i_dbg_chain_router (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .done(done), .done_err(done_err), .done_rdata(done_rdata),
      .spr_req(spr_req), .spr_we(spr_we), .spr_addr(spr_addr), .spr_wdata(spr_wdata),
      .spr_ack(spr_ack), .spr_rdata(spr_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   // special-register responder: acknowledges one cycle after a request
   initial begin
      logic        p_req;
      logic [31:0] p_addr;
      p_req = 1'b0;
      p_addr = '0;
      for (int k = 0; k < 16; k++) spr_store[k] = '0;
      forever begin
         @(posedge clk);
         if (p_req && spr_req && !spr_ack && spr_addr != p_addr) hold_viol++;
         p_req = spr_req && !spr_ack;
         p_addr = spr_addr;
         if (spr_req && !spr_ack) begin
            spr_cycles++;
            spr_rdata <= spr_store[spr_addr[3:0]];
            if (spr_we) spr_store[spr_addr[3:0]] = spr_wdata;
            spr_ack <= 1'b1;
         end else begin
            spr_ack <= 1'b0;
         end
      end
   end

   // byte memory responder with the same handshake
   initial begin
      logic        p_req;
      logic [31:0] p_addr;
      p_req = 1'b0;
      p_addr = '0;
      for (int k = 0; k < 256; k++) bmem[k] = 8'h00;
      forever begin
         @(posedge clk);
         if (p_req && mem_req && !mem_ack && mem_addr != p_addr) hold_viol++;
         p_req = mem_req && !mem_ack;
         p_addr = mem_addr;
         if (mem_req && !mem_ack) begin
            if (mem_cycles < 8) wr_addr_log[mem_cycles] = mem_addr;
            mem_cycles++;
            mem_rdata <= bmem[mem_addr[7:0]];
            if (mem_we) bmem[mem_addr[7:0]] = mem_wdata;
            mem_ack <= 1'b1;
         end else begin
            mem_ack <= 1'b0;
         end
      end
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      summary();
      $finish;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_cmd(input logic [1:0] op, input logic [31:0] a, input logic [31:0] d,
                          output logic [3:0] e, output logic [31:0] r);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_addr  = a;
      cmd_wdata = d;
      @(negedge clk);
      cmd_valid = 1'b0;
      while (!done) @(negedge clk);
      e = done_err;
      r = done_rdata;
      @(negedge clk);
      if (done) pulse_viol++;
   endtask

   task automatic t_reset();
      logic [3:0]  e;
      logic [31:0] r;
      chk("R1 ready after reset", {31'd0, cmd_ready}, 32'd1);
      chk("R1 idle outputs", {29'd0, done, spr_req, mem_req}, 32'd0);
      run_cmd(2'b01, 32'h4, 32'h0, e, r);
      chk("R1 read on global chain", {28'd0, e}, 32'd1);
      run_cmd(2'b10, 32'h4, 32'h1234, e, r);
      chk("R1 write on global chain", {28'd0, e}, 32'd1);
      chk("R1 no bus cycles on global", spr_cycles + mem_cycles, 32'd0);
   endtask

   task automatic t_select();
      logic [3:0]  e;
      logic [31:0] r;
      run_cmd(2'b00, 32'd7, 32'h0, e, r);
      chk("R2 select code 7 rejected", {28'd0, e}, 32'd1);
      run_cmd(2'b00, 32'd0, 32'h0, e, r);
      chk("R2 select code 0 rejected", {28'd0, e}, 32'd1);
      run_cmd(2'b01, 32'd0, 32'h0, e, r);
      chk("R2 selection still global", {28'd0, e}, 32'd1);
      run_cmd(2'b00, 32'd3, 32'h0, e, r);
      chk("R2 select development chain", {28'd0, e}, 32'd0);
   endtask

   task automatic t_devregs();
      logic [3:0]  e;
      logic [31:0] r;
      for (int k = 0; k < 17; k++) begin
         run_cmd(2'b10, k, 32'hC0DE_0000 + k * 32'h0101, e, r);
         if (e != 4'd0) chk("R6 write error code", {28'd0, e}, 32'd0);
      end
      for (int k = 0; k < 17; k++) begin
         run_cmd(2'b01, k, 32'h0, e, r);
         chk("R6 register readback", r, 32'hC0DE_0000 + k * 32'h0101);
      end
      run_cmd(2'b10, 32'd17, 32'hFFFF_FFFF, e, r);
      chk("R7 write out of range", {28'd0, e}, 32'd2);
      run_cmd(2'b01, 32'd17, 32'h0, e, r);
      chk("R7 read out of range error", {28'd0, e}, 32'd2);
      chk("R7 read out of range data", r, 32'h0);
      run_cmd(2'b10, 32'h100, 32'hFFFF_FFFF, e, r);
      run_cmd(2'b01, 32'd16, 32'h0, e, r);
      chk("R7 breakpoint record untouched", r, 32'hC0DE_0000 + 16 * 32'h0101);
      run_cmd(2'b01, 32'd1, 32'h0, e, r);
      chk("R7 trace select untouched", r, 32'hC0DE_0101);
      run_cmd(2'b00, 32'd9, 32'h0, e, r);
      run_cmd(2'b01, 32'd4, 32'h0, e, r);
      chk("R2 bad select keeps development chain", r, 32'hC0DE_0404);
   endtask

   task automatic t_trace();
      logic [3:0]  e;
      logic [31:0] r;
      run_cmd(2'b00, 32'd2, 32'h0, e, r);
      run_cmd(2'b01, 32'h10, 32'h0, e, r);
      chk("R5 trace read data", r, 32'h0);
      chk("R5 trace read error", {28'd0, e}, 32'd0);
      run_cmd(2'b11, 32'h10, 32'h55, e, r);
      chk("R5 trace write error", {28'd0, e}, 32'd3);
   endtask

   task automatic t_spr();
      logic [3:0]  e;
      logic [31:0] r;
      int c0;
      run_cmd(2'b00, 32'd1, 32'h0, e, r);
      c0 = spr_cycles;
      run_cmd(2'b10, 32'h0000_0005, 32'hDEAD_BEEF, e, r);
      chk("R4 spr write error", {28'd0, e}, 32'd0);
      chk("R4 spr write reached port", spr_store[5], 32'hDEAD_BEEF);
      run_cmd(2'b01, 32'h0000_0005, 32'h0, e, r);
      chk("R4 spr read data", r, 32'hDEAD_BEEF);
      chk("R4 spr cycle count", spr_cycles - c0, 32'd2);
   endtask

   task automatic t_mem();
      logic [3:0]  e;
      logic [31:0] r;
      int c0;
      run_cmd(2'b00, 32'd4, 32'h0, e, r);
      c0 = mem_cycles;
      run_cmd(2'b10, 32'h0000_1010, 32'hA1B2_C3D4, e, r);
      chk("R8 write error", {28'd0, e}, 32'd0);
      chk("R8 byte cycle count", mem_cycles - c0, 32'd4);
      chk("R8 bytes big-endian", {bmem[8'h10], bmem[8'h11], bmem[8'h12], bmem[8'h13]},
          32'hA1B2_C3D4);
      chk("R8 first and last address", {wr_addr_log[c0][15:0], wr_addr_log[c0+3][15:0]},
          32'h1010_1013);
      bmem[8'h20] = 8'h11; bmem[8'h21] = 8'h22; bmem[8'h22] = 8'h33; bmem[8'h23] = 8'h44;
      run_cmd(2'b01, 32'h0000_1020, 32'h0, e, r);
      chk("R9 read word assembly", r, 32'h1122_3344);
      c0 = mem_cycles;
      run_cmd(2'b01, 32'h0000_0FFC, 32'h0, e, r);
      chk("R10 below window error", {28'd0, e}, 32'd2);
      run_cmd(2'b10, 32'h0000_1FFD, 32'h1, e, r);
      chk("R10 straddling end error", {28'd0, e}, 32'd2);
      chk("R10 no cycles when invalid", mem_cycles - c0, 32'd0);
      bmem[8'hFC] = 8'h9A; bmem[8'hFD] = 8'hBC; bmem[8'hFE] = 8'hDE; bmem[8'hFF] = 8'hF0;
      run_cmd(2'b01, 32'h0000_1FFC, 32'h0, e, r);
      chk("R10 last valid word error", {28'd0, e}, 32'd0);
      chk("R10 last valid word data", r, 32'h9ABC_DEF0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_select();
      t_devregs();
      t_trace();
      t_spr();
      t_mem();
      chk("R3 done pulse one cycle wide", pulse_viol, 32'd0);
      chk("R11 request fields held", hold_viol, 32'd0);
      summary();
      $finish;
   end

endmodule